// File: doc/BRIEF.md
# T1 Multiframe Overhead Bit Collector

This block gathers the overhead bits (data-link bits or FS bits) of a received T1 stream into two 8-bit registers that software-facing logic can read. A frame strobe arrives once per frame and carries that frame's overhead bit value and its frame number within the multiframe. A format select picks the frame set. In the 12-frame format, register A holds the FS bits of one multiframe. In the 24-frame and 72-frame formats, registers A and B hold data-link bits taken from every second frame over a fixed span.

Bits collect in shadow registers while a multiframe is in progress. On the multiframe-begin pulse the shadows are copied to the readable registers and then cleared. A reader therefore sees the complete content of the previous multiframe, never a half-filled value. Each readable register has its own valid flag. A change of format discards everything gathered so far, and the valid flags stay low until the next multiframe begin.

Top module: `ohb_collector`

## Requirements
- R1: After reset both readable registers are 0 and both valid flags are 0.
- R2: With fmtSel = 1 (24-frame), a strobe on odd frame f in 1..15 stores its bit at regA bit (f-1)/2.
- R3: With fmtSel = 1, a strobe on frame 17, 19, 21 or 23 stores its bit at regB bit (f-17)/2. regB bits 7:4 read 0.
- R4: With fmtSel = 2 (72-frame), even frames 26..40 map to regA bit (f-26)/2, and even frames 42..56 map to regB bit (f-42)/2.
- R5: With fmtSel = 0 (12-frame), even frames 2..12 map to regA bit (f-2)/2. regA bits 7:6 read 0. regB reads 0 and its valid flag stays 0.
- R6: The readable registers change only in the cycle after a multiframe-begin pulse. They then show exactly the bits strobed since the previous pulse, and bits that were not strobed read 0.
- R7: On a multiframe-begin pulse, validA is set in formats 0, 1 and 2, and validB is set in formats 1 and 2. fmtSel = 3 is reserved: it maps no frames and sets neither flag.
- R8: A change of fmtSel clears the shadows, both readable registers and both valid flags in the next cycle. A strobe or multiframe-begin pulse in the cycle of the change is ignored.
- R9: A strobe whose frame number maps to no bit in the active format changes nothing.
- R10: A strobe in the same cycle as a multiframe-begin pulse belongs to the new multiframe. It appears at the following pulse, not at the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fmtSel | input | 2 | Multiframe format: 0 = 12-frame, 1 = 24-frame, 2 = 72-frame, 3 = reserved |
| frameStb | input | 1 | One-cycle strobe per received frame |
| frameNum | input | 7 | Frame number within the multiframe, counted from 1 |
| ohBit | input | 1 | Overhead bit value for the strobed frame |
| mfBegin | input | 1 | Multiframe-begin pulse |
| regA | output | 8 | Readable register A |
| regB | output | 8 | Readable register B |
| validA | output | 1 | regA holds a published multiframe |
| validB | output | 1 | regB holds a published multiframe |

## Verification
A wrong frame-to-bit decode, or a shadow that is not cleared, stays hidden until the next multiframe-begin pulse. One cycle after that pulse it appears as a wrong or stale bit in regA or regB. The bench therefore strokes every frame number from 1 to 72 with pseudo-random bits in every format and compares both registers right after each publish. Before each publish it also checks that nothing has leaked out early. A format tracker that misses a change shows up within one cycle, as valid flags or registers that fail to drop.

// File: rtl/ohb_pkg.sv
package ohb_pkg;
  parameter int REG_W   = 8;
  parameter int FRAME_W = 7;
  localparam int IDX_W  = $clog2(REG_W);

  typedef enum logic [1:0] {
    FMT12  = 2'd0,
    FMT24  = 2'd1,
    FMT72  = 2'd2,
    FMTRSV = 2'd3
  } fmt_e;

  typedef struct packed {
    logic             hitA;
    logic             hitB;
    logic [IDX_W-1:0] idx;
  } bitMap_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             wrA;
    logic             wrB;
    logic [IDX_W-1:0] idx;
    logic             bitVal;
    logic             publish;
    logic             clear;
    logic             setValA;
    logic             setValB;
  } ctlStb_t;

  function automatic bitMap_t mapFrame(fmt_e f, logic [FRAME_W-1:0] n);
    bitMap_t m;
    int baseA, cntA, baseB, cntB, d;
    m = '0;
    case (f)
      FMT12:   begin baseA = 2;  cntA = 6; baseB = 0;  cntB = 0; end
      FMT24:   begin baseA = 1;  cntA = 8; baseB = 17; cntB = 4; end
      FMT72:   begin baseA = 26; cntA = 8; baseB = 42; cntB = 8; end
      default: begin baseA = 0;  cntA = 0; baseB = 0;  cntB = 0; end
    endcase
    d = int'(n) - baseA;
    if (cntA > 0 && d >= 0 && (d % 2) == 0 && (d / 2) < cntA) begin
      m.hitA = 1'b1;
      m.idx  = IDX_W'(d / 2);
    end
    d = int'(n) - baseB;
    if (cntB > 0 && d >= 0 && (d % 2) == 0 && (d / 2) < cntB) begin
      m.hitB = 1'b1;
      m.idx  = IDX_W'(d / 2);
    end
    return m;
  endfunction
endpackage

// File: rtl/ohb_ctrl.sv
module ohb_ctrl
  import ohb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         fmtSel,
  input  logic               frameStb,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic               ohBit,
  input  logic               mfBegin,
  output ctlStb_t            ctl
);
  fmt_e    fmtReg;
  logic    fmtChg;
  bitMap_t map;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fmtReg <= FMT12;
    else if (fmtChg) fmtReg <= fmt_e'(fmtSel);
  end

  always_comb begin
    fmtChg      = (fmt_e'(fmtSel) != fmtReg);
    map         = mapFrame(fmtReg, frameNum);
    ctl.wrA     = frameStb && !fmtChg && map.hitA;
    ctl.wrB     = frameStb && !fmtChg && map.hitB;
    ctl.idx     = map.idx;
    ctl.bitVal  = ohBit;
    ctl.publish = mfBegin && !fmtChg;
    ctl.clear   = fmtChg;
    ctl.setValA = (fmtReg != FMTRSV);
    ctl.setValB = (fmtReg == FMT24) || (fmtReg == FMT72);
  end

  // R3 R4
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.wrA, ctl.wrB}));

  // R5
  no_b_in_f12_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fmtReg == FMT12) |-> !ctl.wrB);

  // R8
  fmt_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fmtChg |=> (fmtReg == fmt_e'($past(fmtSel))));
endmodule

// File: rtl/ohb_dpath.sv
module ohb_dpath
  import ohb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStb_t          ctl,
  output logic [REG_W-1:0] regA,
  output logic [REG_W-1:0] regB,
  output logic             validA,
  output logic             validB
);
  logic [REG_W-1:0] shA, shB, shANext, shBNext;

  always_comb begin
    shANext = ctl.publish ? '0 : shA;
    shBNext = ctl.publish ? '0 : shB;
    if (ctl.wrA) shANext[ctl.idx] = ctl.bitVal;
    if (ctl.wrB) shBNext[ctl.idx] = ctl.bitVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shA <= '0; shB <= '0; regA <= '0; regB <= '0;
      validA <= 1'b0; validB <= 1'b0;
    end else if (ctl.clear) begin
      shA <= '0; shB <= '0; regA <= '0; regB <= '0;
      validA <= 1'b0; validB <= 1'b0;
    end else begin
      shA <= shANext;
      shB <= shBNext;
      if (ctl.publish) begin
        regA   <= shA;
        regB   <= shB;
        validA <= ctl.setValA;
        validB <= ctl.setValB;
      end
    end
  end

  // R6
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.publish && !ctl.clear) |=> ($stable(regA) && $stable(regB) && $stable(validA)));

  // R8
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (!validA && !validB && regA == '0 && regB == '0));

  // R7
  valid_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    validB |-> validA);

  // R6
  shadow_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.publish && !ctl.wrA) |=> (shA == '0));
endmodule

// File: rtl/ohb_collector.sv
module ohb_collector
  import ohb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         fmtSel,
  input  logic               frameStb,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic               ohBit,
  input  logic               mfBegin,
  output logic [REG_W-1:0]   regA,
  output logic [REG_W-1:0]   regB,
  output logic               validA,
  output logic               validB
);
  ctlStb_t ctl;

  ohb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .frameStb(frameStb),
    .frameNum(frameNum), .ohBit(ohBit), .mfBegin(mfBegin), .ctl(ctl)
  );

  ohb_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regA(regA), .regB(regB),
    .validA(validA), .validB(validB)
  );
endmodule

// File: tb/sim_ohb_collector.sv
module sim_ohb_collector;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] fmtSel = 2'd0;
  logic       frameStb = 1'b0;
  logic [6:0] frameNum = 7'd0;
  logic       ohBit = 1'b0;
  logic       mfBegin = 1'b0;
  logic [7:0] regA, regB;
  logic       validA, validB;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;
  logic [72:1] pat;

  always #4 clk = ~clk;

  ohb_collector u0 (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .frameStb(frameStb),
    .frameNum(frameNum), .ohBit(ohBit), .mfBegin(mfBegin),
    .regA(regA), .regB(regB), .validA(validA), .validB(validB)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expA(int f, logic [72:1] p);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      if (f == 0 && i < 6) r[i] = p[2 + 2*i];
      if (f == 1)          r[i] = p[1 + 2*i];
      if (f == 2)          r[i] = p[26 + 2*i];
    end
    return r;
  endfunction

  function automatic logic [7:0] expB(int f, logic [72:1] p);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      if (f == 1 && i < 4) r[i] = p[17 + 2*i];
      if (f == 2)          r[i] = p[42 + 2*i];
    end
    return r;
  endfunction

  task automatic strobe(int f, logic b, logic withMf);
    @(negedge clk);
    frameStb = 1'b1; frameNum = 7'(f); ohBit = b; mfBegin = withMf;
    @(negedge clk);
    frameStb = 1'b0; mfBegin = 1'b0;
  endtask

  task automatic pulseMf();
    @(negedge clk);
    mfBegin = 1'b1;
    @(negedge clk);
    mfBegin = 1'b0;
  endtask

  task automatic setFmt(int f);
    @(negedge clk);
    fmtSel = 2'(f);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] prevA, prevB;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 regA", regA, 0);
    chk("R1 regB", regB, 0);
    chk("R1 validA", validA, 0);
    chk("R1 validB", validB, 0);
    rstN = 1'b1;

    for (int fm = 0; fm < 4; fm++) begin
      setFmt(fm);
      // R8 valid flags drop after a format change
      chk("R8 validA after change", validA, 0);
      chk("R8 validB after change", validB, 0);
      pulseMf();
      for (int rep = 0; rep < 3; rep++) begin
        prevA = regA; prevB = regB;
        for (int f = 1; f <= 72; f++) begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          pat[f] = (rep == 0) ? 1'b1 : lfsr[0];
          strobe(f, pat[f], 1'b0);
        end
        // R6 nothing visible before the pulse; R9 unmapped frames add nothing
        chk("R6 regA held", regA, prevA);
        chk("R6 regB held", regB, prevB);
        pulseMf();
        if (fm == 0) begin
          chk("R5 regA f12", regA, expA(0, pat));
          chk("R5 regB f12", regB, 0);
        end else if (fm == 1) begin
          chk("R2 regA f24", regA, expA(1, pat));
          chk("R3 regB f24", regB, expB(1, pat));
        end else if (fm == 2) begin
          chk("R4 regA f72", regA, expA(2, pat));
          chk("R4 regB f72", regB, expB(2, pat));
        end else begin
          chk("R9 regA reserved", regA, 0);
          chk("R9 regB reserved", regB, 0);
        end
        chk("R7 validA", validA, (fm != 3));
        chk("R7 validB", validB, (fm == 1 || fm == 2));
      end
      // R6 an empty multiframe publishes zeros
      pulseMf();
      chk("R6 empty regA", regA, 0);
      chk("R6 empty regB", regB, 0);
    end

    // R10 strobe coinciding with the pulse belongs to the new multiframe
    setFmt(1);
    strobe(3, 1'b1, 1'b0);
    strobe(1, 1'b1, 1'b1);
    chk("R10 current publish", regA, 8'h02);
    pulseMf();
    chk("R10 next publish", regA, 8'h01);

    // R8 mid-multiframe change clears; strobe in the change cycle ignored
    strobe(5, 1'b1, 1'b0);
    pulseMf();
    chk("R8 pre-change regA", regA, 8'h04);
    strobe(7, 1'b1, 1'b0);
    @(negedge clk);
    fmtSel = 2'd2; frameStb = 1'b1; frameNum = 7'd28; ohBit = 1'b1; mfBegin = 1'b1;
    @(negedge clk);
    frameStb = 1'b0; mfBegin = 1'b0;
    chk("R8 regA cleared", regA, 0);
    chk("R8 validA cleared", validA, 0);
    strobe(26, 1'b1, 1'b0);
    strobe(42, 1'b1, 1'b0);
    pulseMf();
    chk("R8 regA after change", regA, 8'h01);
    chk("R8 regB after change", regB, 8'h01);
    chk("R7 validB f72", validB, 1);

    // R9 unmapped frame in 72-frame format has no effect
    strobe(27, 1'b1, 1'b0);
    strobe(57, 1'b1, 1'b0);
    pulseMf();
    chk("R9 regA unmapped", regA, 0);
    chk("R9 regB unmapped", regB, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule